// File: doc/BRIEF.md
# Instruction Field Decoder

This block turns one 16-bit instruction word of a small load/store processor into the signals that its datapath uses in the same cycle. It has no state. The word is split into a 4-bit operation code, a condition bit, three 3-bit register selects and two zero-extended immediates. From these it derives control hints:

- ALU operation
- register write enable
- memory read and memory write
- branch kind
- which byte an immediate load fills
- which register read ports the word uses
- whether a shift takes its amount from the immediate

The condition bit has a different meaning for each class of operation:

- For add, subtract and compare it selects signed arithmetic.
- For the plain branch it selects a register target instead of an immediate target.
- For the immediate load it selects the upper byte instead of the lower one.

The two reserved operation codes raise an illegal flag and give no side effect.

Field layout: bits [15:12] hold the operation code and bit [11] the condition bit. Bits [10:8] hold the destination select, [7:5] the first source select and [4:2] the second source select. The 8-bit immediate is bits [7:0] and the 5-bit immediate is bits [4:0]. Operation codes: 0 add, 1 subtract, 2 invert, 3 and, 4 or, 5 xor, 6 shift left, 7 shift right, 8 compare, 9 branch, 10 branch-if-equal, 11 immediate load, 12 load, 13 store.

Top module: `instr_decoder`

## Requirements
- R1: opcode_o = instr_i[15:12], cond_o = instr_i[11], rd_sel_o = instr_i[10:8], rm_sel_o = instr_i[7:5], rn_sel_o = instr_i[4:2], imm8_o = instr_i[7:0], imm5_o = instr_i[4:0], for every input word.
- R2: alu_op_o equals the operation code for codes 0 to 8. It is 9 (pass immediate) for code 11 and 15 (no operation) for codes 9, 10, 12, 13, 14 and 15.
- R3: alu_signed_o equals the condition bit for codes 0, 1 and 8, and is 0 for every other code.
- R4: reg_we_o is 1 exactly for codes 0 to 8, 11 and 12.
- R5: mem_rd_o is 1 exactly for code 12, and mem_wr_o is 1 exactly for code 13.
- R6: branch_o is 0 when there is no branch. For code 9 it is 1 (immediate target) when the condition bit is 0 and 2 (register target) when it is 1. For code 10 it is 3 (conditional, register target).
- R7: imm_byte_o is 0 except for code 11. For code 11 it is 1 (lower byte) when the condition bit is 0 and 2 (upper byte) when it is 1.
- R8: rm_used_o is 1 for codes 0, 1, 3 to 8, 10, 12 and 13, and for code 9 with the condition bit set. It is 0 otherwise, so the invert operation (code 2) ignores the first source field.
- R9: rn_used_o is 1 for codes 0 to 5, 8, 10 and 13. shamt_imm_o is 1 exactly for codes 6 and 7.
- R10: codes 14 and 15 set illegal_o to 1 and hold reg_we_o, mem_rd_o, mem_wr_o and rm_used_o at 0, hold branch_o and imm_byte_o at 0, and give alu_op_o 15. illegal_o is 0 for codes 0 to 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Raw instruction word |
| opcode_o | output | 4 | Operation code field |
| cond_o | output | 1 | Condition bit |
| rd_sel_o | output | 3 | Destination register select |
| rm_sel_o | output | 3 | First source register select |
| rn_sel_o | output | 3 | Second source register select |
| imm8_o | output | 8 | 8-bit immediate, zero-extended field |
| imm5_o | output | 5 | 5-bit immediate, zero-extended field |
| alu_op_o | output | 4 | ALU operation hint |
| alu_signed_o | output | 1 | Signed arithmetic select |
| reg_we_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| branch_o | output | 2 | Branch kind |
| imm_byte_o | output | 2 | Immediate byte select |
| rm_used_o | output | 1 | First read port in use |
| rn_used_o | output | 1 | Second read port in use |
| shamt_imm_o | output | 1 | Shift amount comes from imm5 |
| illegal_o | output | 1 | Reserved operation code |

## Verification
The condition bit feeds three interpretations in the same decode: signedness, branch target source and immediate byte. A word with the bit set must wake only the interpretation that its operation code owns. Every operation code is applied with the bit both clear and set, and random words add the rest. On every word all three outputs are compared with bench models, so a leak into a foreign class shows up at once. The reserved codes are also driven with the bit set, to confirm that the illegal path overrides all three interpretations.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

    localparam int unsigned WORD_W   = 16;
    localparam int unsigned OP_W     = 4;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned IMM8_W   = 8;
    localparam int unsigned IMM5_W   = 5;
    localparam int unsigned N_SEL    = 3;
    localparam int unsigned OP_LSB   = WORD_W - OP_W;
    localparam int unsigned COND_BIT = OP_LSB - 1;
    localparam int unsigned RD_LSB   = COND_BIT - SEL_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_INV  = 4'd2,  OP_AND = 4'd3,
        OP_OR   = 4'd4,  OP_XOR  = 4'd5,  OP_SHL  = 4'd6,  OP_SHR = 4'd7,
        OP_CMP  = 4'd8,  OP_JMP  = 4'd9,  OP_JEQ  = 4'd10, OP_LDI = 4'd11,
        OP_LOAD = 4'd12, OP_STOR = 4'd13, OP_RSVE = 4'd14, OP_RSVF = 4'd15
    } opcode_e;

    typedef enum logic [3:0] {
        ALU_ADD  = 4'd0, ALU_SUB = 4'd1, ALU_INV = 4'd2, ALU_AND = 4'd3,
        ALU_OR   = 4'd4, ALU_XOR = 4'd5, ALU_SHL = 4'd6, ALU_SHR = 4'd7,
        ALU_CMP  = 4'd8, ALU_PASS = 4'd9, ALU_NONE = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0, BR_IMM = 2'd1, BR_REG = 2'd2, BR_EQ = 2'd3
    } branch_e;

    typedef enum logic [1:0] {
        BYTE_NONE = 2'd0, BYTE_LOW = 2'd1, BYTE_HIGH = 2'd2
    } byte_sel_e;

    typedef struct packed {
        opcode_e             op;
        logic                cond;
        logic [SEL_W-1:0]    rd;
        logic [SEL_W-1:0]    rm;
        logic [SEL_W-1:0]    rn;
        logic [IMM8_W-1:0]   imm8;
        logic [IMM5_W-1:0]   imm5;
    } fields_t;

    typedef struct packed {
        alu_op_e alu;
        logic    reg_we;
        logic    mem_rd;
        logic    mem_wr;
        logic    rm_used;
        logic    rn_used;
        logic    shamt_imm;
        logic    illegal;
    } ctrl_t;

    typedef struct packed {
        logic      alu_signed;
        branch_e   branch;
        byte_sel_e byte_sel;
        logic      rm_extra;
    } steer_t;

    function automatic logic op_is_signable(opcode_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
    endfunction

    function automatic logic op_is_reserved(opcode_e op);
        return (op == OP_RSVE) || (op == OP_RSVF);
    endfunction

endpackage

// File: rtl/isa_field_split.sv
module isa_field_split
    import isa_dec_pkg::*;
(
    input  logic [WORD_W-1:0] instr_i,
    output fields_t           fields_o
);
    logic [N_SEL-1:0][SEL_W-1:0] sel;

    generate
        for (genvar g = 0; g < N_SEL; g++) begin : g_sel
            assign sel[g] = instr_i[RD_LSB - g*SEL_W +: SEL_W];
        end
    endgenerate

    always_comb begin
        fields_o.op   = opcode_e'(instr_i[OP_LSB +: OP_W]);
        fields_o.cond = instr_i[COND_BIT];
        fields_o.rd   = sel[0];
        fields_o.rm   = sel[1];
        fields_o.rn   = sel[2];
        fields_o.imm8 = instr_i[IMM8_W-1:0];
        fields_o.imm5 = instr_i[IMM5_W-1:0];
    end

    always_comb begin
        a_r1_imm_nested: assert (fields_o.imm5 == fields_o.imm8[IMM5_W-1:0])
            else $error("R1 imm5 not nested in imm8");
    end
endmodule

// File: rtl/isa_ctrl_table.sv
module isa_ctrl_table
    import isa_dec_pkg::*;
(
    input  opcode_e op_i,
    output ctrl_t   ctrl_o
);
    always_comb begin
        ctrl_o = '{alu: ALU_NONE, reg_we: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
                   rm_used: 1'b0, rn_used: 1'b0, shamt_imm: 1'b0, illegal: 1'b0};
        case (op_i)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_CMP: begin
                ctrl_o.alu     = alu_op_e'(op_i);
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.rm_used = 1'b1;
                ctrl_o.rn_used = 1'b1;
            end
            OP_INV: begin
                ctrl_o.alu     = ALU_INV;
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.rn_used = 1'b1;
            end
            OP_SHL, OP_SHR: begin
                ctrl_o.alu       = alu_op_e'(op_i);
                ctrl_o.reg_we    = 1'b1;
                ctrl_o.rm_used   = 1'b1;
                ctrl_o.shamt_imm = 1'b1;
            end
            OP_JMP: ;
            OP_JEQ: begin
                ctrl_o.rm_used = 1'b1;
                ctrl_o.rn_used = 1'b1;
            end
            OP_LDI: begin
                ctrl_o.alu    = ALU_PASS;
                ctrl_o.reg_we = 1'b1;
            end
            OP_LOAD: begin
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.mem_rd  = 1'b1;
                ctrl_o.rm_used = 1'b1;
            end
            OP_STOR: begin
                ctrl_o.mem_wr  = 1'b1;
                ctrl_o.rm_used = 1'b1;
                ctrl_o.rn_used = 1'b1;
            end
            default: ctrl_o.illegal = 1'b1;
        endcase
    end

    always_comb begin
        a_r5_mem_exclusive: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr))
            else $error("R5 read and write together");
        a_r10_illegal_quiet: assert (!op_is_reserved(op_i) ||
                (!ctrl_o.reg_we && !ctrl_o.mem_rd && !ctrl_o.mem_wr && ctrl_o.alu == ALU_NONE))
            else $error("R10 reserved code has side effect");
        a_r9_shift_no_rn: assert (!ctrl_o.shamt_imm || !ctrl_o.rn_used)
            else $error("R9 shift reads second port");
    end
endmodule

// File: rtl/isa_cond_steer.sv
module isa_cond_steer
    import isa_dec_pkg::*;
(
    input  opcode_e op_i,
    input  logic    cond_i,
    output steer_t  steer_o
);
    always_comb begin
        steer_o.alu_signed = op_is_signable(op_i) & cond_i;
        steer_o.rm_extra   = 1'b0;
        case (op_i)
            OP_JMP: begin
                steer_o.branch   = cond_i ? BR_REG : BR_IMM;
                steer_o.rm_extra = cond_i;
            end
            OP_JEQ:  steer_o.branch = BR_EQ;
            default: steer_o.branch = BR_NONE;
        endcase
        if (op_i == OP_LDI)
            steer_o.byte_sel = cond_i ? BYTE_HIGH : BYTE_LOW;
        else
            steer_o.byte_sel = BYTE_NONE;
    end

    always_comb begin
        a_r7_byte_only_ldi: assert (steer_o.byte_sel == BYTE_NONE || op_i == OP_LDI)
            else $error("R7 byte select outside immediate load");
        a_r3_sign_needs_cond: assert (!steer_o.alu_signed || cond_i)
            else $error("R3 signed without condition bit");
    end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import isa_dec_pkg::*;
(
    input  logic [15:0] instr_i,
    output logic [3:0]  opcode_o,
    output logic        cond_o,
    output logic [2:0]  rd_sel_o,
    output logic [2:0]  rm_sel_o,
    output logic [2:0]  rn_sel_o,
    output logic [7:0]  imm8_o,
    output logic [4:0]  imm5_o,
    output logic [3:0]  alu_op_o,
    output logic        alu_signed_o,
    output logic        reg_we_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic [1:0]  branch_o,
    output logic [1:0]  imm_byte_o,
    output logic        rm_used_o,
    output logic        rn_used_o,
    output logic        shamt_imm_o,
    output logic        illegal_o
);
    fields_t f;
    ctrl_t   c;
    steer_t  s;

    isa_field_split u_split (.instr_i(instr_i), .fields_o(f));
    isa_ctrl_table  u_table (.op_i(f.op), .ctrl_o(c));
    isa_cond_steer  u_steer (.op_i(f.op), .cond_i(f.cond), .steer_o(s));

    assign opcode_o     = f.op;
    assign cond_o       = f.cond;
    assign rd_sel_o     = f.rd;
    assign rm_sel_o     = f.rm;
    assign rn_sel_o     = f.rn;
    assign imm8_o       = f.imm8;
    assign imm5_o       = f.imm5;
    assign alu_op_o     = c.alu;
    assign alu_signed_o = s.alu_signed;
    assign reg_we_o     = c.reg_we;
    assign mem_rd_o     = c.mem_rd;
    assign mem_wr_o     = c.mem_wr;
    assign branch_o     = s.branch;
    assign imm_byte_o   = s.byte_sel;
    assign rm_used_o    = c.rm_used | s.rm_extra;
    assign rn_used_o    = c.rn_used;
    assign shamt_imm_o  = c.shamt_imm;
    assign illegal_o    = c.illegal;

    always_comb begin
        a_r6_branch_no_write: assert (s.branch == BR_NONE || (!c.reg_we && !c.mem_wr))
            else $error("R6 branch with write");
        a_r10_illegal_no_branch: assert (!c.illegal || (s.branch == BR_NONE && s.byte_sel == BYTE_NONE))
            else $error("R10 reserved code steers");
        a_r4_write_has_alu_or_load: assert (!c.reg_we || c.alu != ALU_NONE || c.mem_rd)
            else $error("R4 write with no source");
    end
endmodule

// File: tb/tb_instr_decoder.sv
module tb_instr_decoder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [15:0] instr_i = 16'h0000;
    logic [3:0]  opcode_o, alu_op_o;
    logic        cond_o, alu_signed_o, reg_we_o, mem_rd_o, mem_wr_o;
    logic [2:0]  rd_sel_o, rm_sel_o, rn_sel_o;
    logic [7:0]  imm8_o;
    logic [4:0]  imm5_o;
    logic [1:0]  branch_o, imm_byte_o;
    logic        rm_used_o, rn_used_o, shamt_imm_o, illegal_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    instr_decoder dut (.*);

    function automatic int e_alu(int op);
        if (op <= 8) return op;
        if (op == 11) return 9;
        return 15;
    endfunction
    function automatic int e_signed(int op, int c);
        return ((op == 0 || op == 1 || op == 8) && c == 1) ? 1 : 0;
    endfunction
    function automatic int e_we(int op);
        return (op <= 8 || op == 11 || op == 12) ? 1 : 0;
    endfunction
    function automatic int e_br(int op, int c);
        if (op == 9) return c ? 2 : 1;
        if (op == 10) return 3;
        return 0;
    endfunction
    function automatic int e_byte(int op, int c);
        if (op == 11) return c ? 2 : 1;
        return 0;
    endfunction
    function automatic int e_rm(int op, int c);
        case (op)
            0, 1, 3, 4, 5, 6, 7, 8, 10, 12, 13: return 1;
            9: return c;
            default: return 0;
        endcase
    endfunction
    function automatic int e_rn(int op);
        case (op)
            0, 1, 2, 3, 4, 5, 8, 10, 13: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp, logic [15:0] w);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s word=%h actual=%0d expected=%0d", req, w, act, exp);
        end
    endtask

    task automatic check_word(logic [15:0] w);
        int op = int'(w[15:12]);
        int c  = int'(w[11]);
        chk("R1 opcode", int'(opcode_o), op, w);
        chk("R1 cond",   int'(cond_o), c, w);
        chk("R1 rd",     int'(rd_sel_o), int'(w[10:8]), w);
        chk("R1 rm",     int'(rm_sel_o), int'(w[7:5]), w);
        chk("R1 rn",     int'(rn_sel_o), int'(w[4:2]), w);
        chk("R1 imm8",   int'(imm8_o), int'(w[7:0]), w);
        chk("R1 imm5",   int'(imm5_o), int'(w[4:0]), w);
        chk("R2 alu",    int'(alu_op_o), e_alu(op), w);
        chk("R3 signed", int'(alu_signed_o), e_signed(op, c), w);
        chk("R4 we",     int'(reg_we_o), e_we(op), w);
        chk("R5 mrd",    int'(mem_rd_o), (op == 12) ? 1 : 0, w);
        chk("R5 mwr",    int'(mem_wr_o), (op == 13) ? 1 : 0, w);
        chk("R6 branch", int'(branch_o), e_br(op, c), w);
        chk("R7 byte",   int'(imm_byte_o), e_byte(op, c), w);
        chk("R8 rm_used", int'(rm_used_o), e_rm(op, c), w);
        chk("R9 rn_used", int'(rn_used_o), e_rn(op), w);
        chk("R9 shamt",  int'(shamt_imm_o), (op == 6 || op == 7) ? 1 : 0, w);
        chk("R10 illegal", int'(illegal_o), (op >= 14) ? 1 : 0, w);
    endtask

    task automatic apply(logic [15:0] w);
        @(posedge clk);
        #1 instr_i = w;
        @(negedge clk);
        check_word(w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_word(16'h0000);             // reset-time state with all-zero word
        rst = 1'b0;
        for (int op = 0; op < 16; op++) begin
            apply({op[3:0], 1'b0, 11'h5A3});
            apply({op[3:0], 1'b1, 11'h2DC});  // R3 R6 R7 steering with cond set
        end
        apply(16'h2FFF);                  // R8 invert with all-ones source fields
        apply(16'hBFFF);                  // R7 upper byte load, maximal immediate
        apply(16'hF800);                  // R10 reserved with cond set
        apply(16'hE7FF);                  // R10 reserved with cond clear
        for (int i = 0; i < 3000; i++) apply(16'($urandom));
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule